// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the raster timing for a panel display. A pixel-rate step enable comes from one of three clock-enable inputs, chosen by a source field, and passes through a 5-bit divider. A horizontal and a vertical counter run at that rate. Each line is laid out as active pixels, then front porch, then the sync pulse, then back porch. Each frame follows the same pattern, counted in lines. The counters wrap at the sum of the four segments in each direction.

From the counters the block derives HSYNC, VSYNC, display enable and a data-bus valid mask. It also presents the current pixel coordinates. Every output has its own polarity control. HSYNC and VSYNC can each be held inactive while the frame is in its vertical sync rows. An AC modulation output toggles after a programmable number of lines. A vertical-sync interrupt gives a one-cycle pulse and a sticky status bit.

A display-on input holds the counters at zero and every output at its inactive level while it is low. All settings are plain inputs that are sampled every clock.

Top module: `lcd_timing_gen`

## Requirements
- R1: `clk_src` selects the step enable: 0 selects `ce_bus`, 1 selects `ce_periph`, 2 selects `ce_ext`, and 3 selects none, which freezes the counters.
- R2: The pixel counters advance once per N selected enable pulses, where N is `clk_div`. A value of 0 behaves as 1.
- R3: `pix_x` counts from 0 to htotal-1, where htotal = h_active+h_front+h_sync+h_back. `pix_y` advances on each wrap of `pix_x` and wraps at vtotal-1, where vtotal is formed the same way. All registered outputs reflect the counter state of the previous clock.
- R4: The unpolarised HSYNC is high for x in [h_active+h_front, h_active+h_front+h_sync). The unpolarised VSYNC is high for y in [v_active+v_front, v_active+v_front+v_sync). `pol_hsync_inv` inverts `hsync` and `pol_vsync_inv` inverts `vsync`.
- R5: The unpolarised enable is high when x < h_active and y < v_active. `de` equals that value, inverted when `pol_de_low`=1. `data_mask` equals that value, inverted when `pol_data_inv`=1.
- R6: With `hs_supp`=1, the unpolarised HSYNC is 0 on every line inside the vertical sync rows.
- R7: With `vs_supp`=1, the unpolarised VSYNC is always 0.
- R8: With `mod_en`=0, `mod_out` is 0. With `mod_en`=1 and `mod_lines`=M>0, `mod_out` toggles on the edge that completes every M-th line. With M=0 it holds its level.
- R9: The event is the first cycle in which the frame is inside the vertical sync rows; `vs_supp` does not affect it. The event sets `irq_status`, and `irq_pulse` is high for one cycle when `irq_en`=1. `irq_clr`=1 clears the status, but an event in the same cycle wins.
- R10: With `disp_on`=0, the divider and counters reset and `pix_x`/`pix_y` read 0 one clock later. `mod_out` reads 0, and each sync, enable and mask output sits at its inactive level, which is its polarity bit.
- R11: After a synchronous reset with all polarity bits 0, every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_bus | input | 1 | Clock enable, source 0 |
| ce_periph | input | 1 | Clock enable, source 1 |
| ce_ext | input | 1 | Clock enable, source 2 |
| clk_src | input | 2 | Step enable source select |
| clk_div | input | DIVW | Pixel divider (0 behaves as 1) |
| disp_on | input | 1 | Display on |
| h_active | input | HW | Active pixels per line |
| h_front | input | HW | Horizontal front porch |
| h_sync | input | HW | HSYNC width |
| h_back | input | HW | Horizontal back porch |
| v_active | input | VW | Active lines |
| v_front | input | VW | Vertical front porch |
| v_sync | input | VW | VSYNC width in lines |
| v_back | input | VW | Vertical back porch |
| pol_hsync_inv | input | 1 | Invert HSYNC |
| pol_vsync_inv | input | 1 | Invert VSYNC |
| pol_de_low | input | 1 | Display enable active low |
| pol_data_inv | input | 1 | Invert data valid mask |
| hs_supp | input | 1 | Suppress HSYNC in vertical sync rows |
| vs_supp | input | 1 | Suppress VSYNC |
| mod_en | input | 1 | AC modulation enable |
| mod_lines | input | VW | Lines per modulation toggle |
| irq_en | input | 1 | Interrupt pulse enable |
| irq_clr | input | 1 | Clear interrupt status |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| data_mask | output | 1 | Data-bus valid mask |
| pix_x | output | HW | Current pixel column |
| pix_y | output | VW | Current line |
| mod_out | output | 1 | AC modulation |
| irq_pulse | output | 1 | One-cycle vertical sync interrupt |
| irq_status | output | 1 | Sticky interrupt status |

## Verification
The bench drives each source at a different enable rate, so a wrong source decode shifts the pixel cadence at once. A divider value of zero is also applied; a design that takes it literally would stall or run fast. Suppression is combined with inverted polarity. A design that suppressed after the inversion, or dropped HSYNC outside the vertical sync rows, would show wrong sync levels on the compared cycles. Modulation counts of 2, 3 and 0 expose off-by-one toggling. Clearing the status while the interrupt is disabled, and turning the display off mid-frame with an active-low enable, reveal a lost event or an output left at the wrong idle level.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  typedef enum logic [1:0] {
    SRC_BUS    = 2'd0,
    SRC_PERIPH = 2'd1,
    SRC_EXT    = 2'd2,
    SRC_NONE   = 2'd3
  } clk_src_e;
endpackage

// File: rtl/lcd_tg_clkdiv.sv
module lcd_tg_clkdiv #(
  parameter int DIVW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            ce_bus,
  input  logic            ce_periph,
  input  logic            ce_ext,
  input  logic [1:0]      src,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  import lcd_tg_pkg::*;

  logic            sel_ce;
  logic [DIVW-1:0] eff;
  logic [DIVW-1:0] cnt;
  logic            last;

  always_comb begin
    case (clk_src_e'(src))
      SRC_BUS:    sel_ce = ce_bus;
      SRC_PERIPH: sel_ce = ce_periph;
      SRC_EXT:    sel_ce = ce_ext;
      default:    sel_ce = 1'b0;
    endcase
  end

  assign eff  = (div == '0) ? DIVW'(1) : div;
  assign last = (cnt >= eff - DIVW'(1));
  assign tick = run && sel_ce && last;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (sel_ce) cnt <= last ? '0 : cnt + DIVW'(1);
  end
endmodule

// File: rtl/lcd_tg_counters.sv
module lcd_tg_counters #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic [HW-1:0] h_active,
  input  logic [HW-1:0] h_front,
  input  logic [HW-1:0] h_sync,
  input  logic [HW-1:0] h_back,
  input  logic [VW-1:0] v_active,
  input  logic [VW-1:0] v_front,
  input  logic [VW-1:0] v_sync,
  input  logic [VW-1:0] v_back,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          line_end
);
  localparam int HSW = HW + 2;
  localparam int VSW = VW + 2;

  logic [HSW-1:0] h_tot;
  logic [VSW-1:0] v_tot;
  logic           frame_end;

  assign h_tot = HSW'(h_active) + HSW'(h_front) + HSW'(h_sync) + HSW'(h_back);
  assign v_tot = VSW'(v_active) + VSW'(v_front) + VSW'(v_sync) + VSW'(v_back);

  assign line_end  = tick && (HSW'(hcnt) >= h_tot - HSW'(1));
  assign frame_end = line_end && (VSW'(vcnt) >= v_tot - VSW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (tick) begin
      if (line_end) begin
        hcnt <= '0;
        vcnt <= frame_end ? '0 : vcnt + VW'(1);
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end
endmodule

// File: rtl/lcd_tg_acmod.sv
module lcd_tg_acmod #(
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          line_end,
  input  logic          mod_en,
  input  logic [VW-1:0] mod_lines,
  output logic          mod_out
);
  logic [VW-1:0] lines_seen;

  always_ff @(posedge clk) begin
    if (rst || !run || !mod_en) begin
      lines_seen <= '0;
      mod_out    <= 1'b0;
    end else if (line_end && mod_lines != '0) begin
      if (lines_seen >= mod_lines - VW'(1)) begin
        lines_seen <= '0;
        mod_out    <= ~mod_out;
      end else begin
        lines_seen <= lines_seen + VW'(1);
      end
    end
  end
endmodule

// File: rtl/lcd_tg_sigout.sv
module lcd_tg_sigout #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic [HW-1:0] h_active,
  input  logic [HW-1:0] h_front,
  input  logic [HW-1:0] h_sync,
  input  logic [VW-1:0] v_active,
  input  logic [VW-1:0] v_front,
  input  logic [VW-1:0] v_sync,
  input  logic          pol_hsync_inv,
  input  logic          pol_vsync_inv,
  input  logic          pol_de_low,
  input  logic          pol_data_inv,
  input  logic          hs_supp,
  input  logic          vs_supp,
  input  logic          irq_en,
  input  logic          irq_clr,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          data_mask,
  output logic [HW-1:0] pix_x,
  output logic [VW-1:0] pix_y,
  output logic          irq_pulse,
  output logic          irq_status
);
  localparam int HSW = HW + 2;
  localparam int VSW = VW + 2;

  logic [HSW-1:0] hs_lo, hs_hi, hx;
  logic [VSW-1:0] vs_lo, vs_hi, vy;
  logic           de_raw, hs_raw, vwin, vwin_q, evt;

  assign hx    = HSW'(hcnt);
  assign vy    = VSW'(vcnt);
  assign hs_lo = HSW'(h_active) + HSW'(h_front);
  assign hs_hi = hs_lo + HSW'(h_sync);
  assign vs_lo = VSW'(v_active) + VSW'(v_front);
  assign vs_hi = vs_lo + VSW'(v_sync);

  assign de_raw = run && (hcnt < h_active) && (vcnt < v_active);
  assign hs_raw = run && (hx >= hs_lo) && (hx < hs_hi);
  assign vwin   = run && (vy >= vs_lo) && (vy < vs_hi);
  assign evt    = vwin && !vwin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync      <= pol_hsync_inv;
      vsync      <= pol_vsync_inv;
      de         <= pol_de_low;
      data_mask  <= pol_data_inv;
      pix_x      <= '0;
      pix_y      <= '0;
      vwin_q     <= 1'b0;
      irq_pulse  <= 1'b0;
      irq_status <= 1'b0;
    end else begin
      hsync      <= (hs_raw && !(hs_supp && vwin)) ^ pol_hsync_inv;
      vsync      <= (vwin && !vs_supp) ^ pol_vsync_inv;
      de         <= de_raw ^ pol_de_low;
      data_mask  <= de_raw ^ pol_data_inv;
      pix_x      <= run ? hcnt : '0;
      pix_y      <= run ? vcnt : '0;
      vwin_q     <= vwin;
      irq_pulse  <= evt && irq_en;
      irq_status <= evt ? 1'b1 : (irq_clr ? 1'b0 : irq_status);
    end
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int HW   = 12,
  parameter int VW   = 11,
  parameter int DIVW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce_bus,
  input  logic            ce_periph,
  input  logic            ce_ext,
  input  logic [1:0]      clk_src,
  input  logic [DIVW-1:0] clk_div,
  input  logic            disp_on,
  input  logic [HW-1:0]   h_active,
  input  logic [HW-1:0]   h_front,
  input  logic [HW-1:0]   h_sync,
  input  logic [HW-1:0]   h_back,
  input  logic [VW-1:0]   v_active,
  input  logic [VW-1:0]   v_front,
  input  logic [VW-1:0]   v_sync,
  input  logic [VW-1:0]   v_back,
  input  logic            pol_hsync_inv,
  input  logic            pol_vsync_inv,
  input  logic            pol_de_low,
  input  logic            pol_data_inv,
  input  logic            hs_supp,
  input  logic            vs_supp,
  input  logic            mod_en,
  input  logic [VW-1:0]   mod_lines,
  input  logic            irq_en,
  input  logic            irq_clr,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic            data_mask,
  output logic [HW-1:0]   pix_x,
  output logic [VW-1:0]   pix_y,
  output logic            mod_out,
  output logic            irq_pulse,
  output logic            irq_status
);
  logic          tick, line_end;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  lcd_tg_clkdiv #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst(rst), .run(disp_on),
    .ce_bus(ce_bus), .ce_periph(ce_periph), .ce_ext(ce_ext),
    .src(clk_src), .div(clk_div), .tick(tick)
  );

  lcd_tg_counters #(.HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst(rst), .run(disp_on), .tick(tick),
    .h_active(h_active), .h_front(h_front), .h_sync(h_sync), .h_back(h_back),
    .v_active(v_active), .v_front(v_front), .v_sync(v_sync), .v_back(v_back),
    .hcnt(hcnt), .vcnt(vcnt), .line_end(line_end)
  );

  lcd_tg_acmod #(.VW(VW)) u_mod (
    .clk(clk), .rst(rst), .run(disp_on), .line_end(line_end),
    .mod_en(mod_en), .mod_lines(mod_lines), .mod_out(mod_out)
  );

  lcd_tg_sigout #(.HW(HW), .VW(VW)) u_out (
    .clk(clk), .rst(rst), .run(disp_on), .hcnt(hcnt), .vcnt(vcnt),
    .h_active(h_active), .h_front(h_front), .h_sync(h_sync),
    .v_active(v_active), .v_front(v_front), .v_sync(v_sync),
    .pol_hsync_inv(pol_hsync_inv), .pol_vsync_inv(pol_vsync_inv),
    .pol_de_low(pol_de_low), .pol_data_inv(pol_data_inv),
    .hs_supp(hs_supp), .vs_supp(vs_supp),
    .irq_en(irq_en), .irq_clr(irq_clr),
    .hsync(hsync), .vsync(vsync), .de(de), .data_mask(data_mask),
    .pix_x(pix_x), .pix_y(pix_y),
    .irq_pulse(irq_pulse), .irq_status(irq_status)
  );
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          disp_on,
  input logic          pol_de_low,
  input logic          mod_en,
  input logic          irq_clr,
  input logic [HW-1:0] pix_x,
  input logic [VW-1:0] pix_y,
  input logic          de,
  input logic          mod_out,
  input logic          irq_pulse,
  input logic          irq_status
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst) irq_pulse |=> !irq_pulse); // R9
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst) (irq_status && !irq_clr) |=> irq_status); // R9
  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (rst) irq_pulse |-> irq_status); // R9
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst) !disp_on |=> (pix_x == '0 && pix_y == '0)); // R10
  AST_OFF_DE: assert property (@(posedge clk) disable iff (rst) !disp_on |=> (de == $past(pol_de_low))); // R10
  AST_MOD_QUIET: assert property (@(posedge clk) disable iff (rst) !mod_en |=> !mod_out); // R8
  AST_X_STEP: assert property (@(posedge clk) disable iff (rst)
    (pix_x != $past(pix_x)) |-> (pix_x == $past(pix_x) + HW'(1) || pix_x == '0)); // R3
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .disp_on(disp_on), .pol_de_low(pol_de_low),
  .mod_en(mod_en), .irq_clr(irq_clr), .pix_x(pix_x), .pix_y(pix_y),
  .de(de), .mod_out(mod_out), .irq_pulse(irq_pulse), .irq_status(irq_status)
);

// File: tb/lcd_timing_gen_test.sv
`timescale 1ns/1ps
module lcd_timing_gen_test;
  localparam int HW = 12, VW = 11, DIVW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic ce_bus = 0, ce_periph = 0, ce_ext = 0;
  logic [1:0] clk_src = 0;
  logic [DIVW-1:0] clk_div = 0;
  logic disp_on = 0;
  logic [HW-1:0] h_active = 4, h_front = 1, h_sync = 2, h_back = 1;
  logic [VW-1:0] v_active = 3, v_front = 1, v_sync = 2, v_back = 1;
  logic pol_hsync_inv = 0, pol_vsync_inv = 0, pol_de_low = 0, pol_data_inv = 0;
  logic hs_supp = 0, vs_supp = 0, mod_en = 0, irq_en = 1, irq_clr = 0;
  logic [VW-1:0] mod_lines = 0;
  logic hsync, vsync, de, data_mask, mod_out, irq_pulse, irq_status;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] pix_y;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lcd_timing_gen #(.HW(HW), .VW(VW), .DIVW(DIVW)) uut (.*);

  // behavioural reference state
  int m_div, m_h, m_v, m_lc, m_mod, m_vq;
  int e_hs, e_vs, e_de, e_dm, e_x, e_y, e_irq, e_st;

  always @(posedge clk) begin
    int ht, vt, hlo, vlo, eff, sel, tick, lend, fend, act, hsr, vwin, ev;
    cyc++;
    if (rst) begin
      m_div = 0; m_h = 0; m_v = 0; m_lc = 0; m_mod = 0; m_vq = 0;
      e_hs = pol_hsync_inv; e_vs = pol_vsync_inv; e_de = pol_de_low; e_dm = pol_data_inv;
      e_x = 0; e_y = 0; e_irq = 0; e_st = 0;
    end else begin
      ht = h_active + h_front + h_sync + h_back;
      vt = v_active + v_front + v_sync + v_back;
      hlo = h_active + h_front;
      vlo = v_active + v_front;
      act  = disp_on && (m_h < h_active) && (m_v < v_active);
      hsr  = disp_on && (m_h >= hlo) && (m_h < hlo + h_sync);
      vwin = disp_on && (m_v >= vlo) && (m_v < vlo + v_sync);
      ev   = vwin && !m_vq;
      e_hs = (hsr && !(hs_supp && vwin)) ^ pol_hsync_inv;
      e_vs = (vwin && !vs_supp) ^ pol_vsync_inv;
      e_de = act ^ pol_de_low;
      e_dm = act ^ pol_data_inv;
      e_x = disp_on ? m_h : 0;
      e_y = disp_on ? m_v : 0;
      e_irq = ev && irq_en;
      if (ev) e_st = 1; else if (irq_clr) e_st = 0;
      m_vq = vwin;
      case (clk_src)
        2'd0: sel = ce_bus;
        2'd1: sel = ce_periph;
        2'd2: sel = ce_ext;
        default: sel = 0;
      endcase
      eff = (clk_div == 0) ? 1 : clk_div;
      tick = 0;
      if (!disp_on) m_div = 0;
      else if (sel) begin
        if (m_div >= eff - 1) begin m_div = 0; tick = 1; end
        else m_div++;
      end
      lend = tick && (m_h >= ht - 1);
      fend = lend && (m_v >= vt - 1);
      if (!disp_on || !mod_en) begin m_lc = 0; m_mod = 0; end
      else if (lend && mod_lines != 0) begin
        if (m_lc >= mod_lines - 1) begin m_lc = 0; m_mod = !m_mod; end
        else m_lc++;
      end
      if (!disp_on) begin m_h = 0; m_v = 0; end
      else if (tick) begin
        if (lend) begin m_h = 0; m_v = fend ? 0 : m_v + 1; end
        else m_h++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R1 R2 R3 pix_x", pix_x, e_x);
      chk("R3 pix_y", pix_y, e_y);
      chk("R4 R6 hsync", hsync, e_hs);
      chk("R4 R7 vsync", vsync, e_vs);
      chk("R5 de", de, e_de);
      chk("R5 data_mask", data_mask, e_dm);
      chk("R8 mod_out", mod_out, m_mod);
      chk("R9 irq_pulse", irq_pulse, e_irq);
      chk("R9 irq_status", irq_status, e_st);
    end
  end

  task automatic run_cycles(input int n);
    repeat (n) begin
      @(negedge clk);
      ce_bus    = 1'b1;
      ce_periph = (cyc % 2) == 0;
      ce_ext    = (cyc % 3) == 0;
    end
  endtask

  initial begin
    int px;
    run_cycles(3);
    // R11 reset state
    chk("R11 reset hsync", hsync, 0);
    chk("R11 reset vsync", vsync, 0);
    chk("R11 reset de", de, 0);
    chk("R11 reset data_mask", data_mask, 0);
    chk("R11 reset pix", pix_x + pix_y, 0);
    chk("R11 reset irq", irq_pulse + irq_status + mod_out, 0);
    rst = 0;
    cmp_on = 1;
    run_cycles(5);
    chk("R10 off de", de, 0);
    chk("R10 off pix_x", pix_x, 0);
    disp_on = 1;
    run_cycles(120);
    clk_div = 1; run_cycles(60);
    clk_div = 3; run_cycles(200);
    irq_clr = 1; run_cycles(1); irq_clr = 0;
    clk_src = 1; clk_div = 2; run_cycles(250);
    clk_src = 2; clk_div = 1; run_cycles(200);
    clk_src = 3; run_cycles(2);
    px = pix_x;
    run_cycles(20);
    chk("R1 source 3 frozen", pix_x, px);
    clk_src = 0; clk_div = 1;
    pol_hsync_inv = 1; pol_vsync_inv = 1; pol_de_low = 1; pol_data_inv = 1;
    run_cycles(120);
    hs_supp = 1; run_cycles(120);
    vs_supp = 1; run_cycles(120);
    pol_hsync_inv = 0; pol_vsync_inv = 0; pol_de_low = 0; pol_data_inv = 0;
    run_cycles(120);
    hs_supp = 0; vs_supp = 0;
    mod_en = 1; mod_lines = 2; run_cycles(200);
    mod_lines = 3; run_cycles(200);
    mod_lines = 0; run_cycles(100);
    irq_en = 0; run_cycles(120);
    irq_clr = 1; run_cycles(3); irq_clr = 0;
    irq_en = 1;
    h_active = 5; h_front = 2; h_sync = 1; h_back = 2;
    v_active = 2; v_front = 2; v_sync = 1; v_back = 1;
    run_cycles(200);
    pol_de_low = 1; disp_on = 0;
    run_cycles(2);
    chk("R10 off de low-active", de, 1);
    chk("R10 off pix_x", pix_x, 0);
    chk("R10 off mod", mod_out, 0);
    run_cycles(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule